// File: doc/BRIEF.md
# Backlight Level to Duty Converter

This block turns an 8-bit brightness request into the 16-bit active-duty word that a backlight PWM counter compares against. The level is first widened to an unsigned 1.16 fraction: its bits are repeated three times, which scales the value by 256/255, and the result is rounded. That fraction is then multiplied by the PWM period, and the product is brought back to a 16-bit duty word by a shift that depends on the programmed counter bit width.

The same unit also runs the reverse conversion. A duty word that is already programmed, together with its period, is turned back into a rounded 16-bit brightness. This path uses a restoring divider that takes several cycles. The upper byte of every result is also provided as an 8-bit readback.

A mode input chooses the direction. Operands enter through a valid/ready handshake, and only one operation is in flight at a time. The result stays on the output, marked valid, until the consumer accepts it.

Top module: `bl_duty_conv`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0 and `out_data` is 0.
- R2: In forward mode (`in_mode` = 0) the level L is widened to S = ({L,L,L} >> 8) + bit 7 of {L,L,L}. This is a 17-bit unsigned 1.16 value; for example 0xEF gives 0xEFF0 and 0xFF gives 0x10000.
- R3: A `in_bitcnt` field of 0 stands for a bit width n of 16; any other value v stands for n = v. The period is masked to its low n bits before use, so period 0x0100 with n = 8 acts as 0.
- R4: In forward mode, with P the masked period and X = S·P, the result is ((X >> n) mod 2^16) + bit (n−1) of X, truncated to 16 bits. Level 0xEF, period 0x24 and n = 6 give 0x86F7.
- R5: In reverse mode (`in_mode` = 1) the masked period P is replaced by 0xFFFF when it is 0. Then Q = (D << (n+1)) / P, rounded down; Q' = (Q+1) >> 1; Y = Q'·P. The result is ((Y >> n) + bit (n−1) of Y), truncated to 16 bits.
- R6: `out_byte` always equals bits 15:8 of `out_data`.
- R7: `in_ready` is high only when no operation is in flight. Inputs offered while `in_ready` is low are ignored and do not alter the result in progress.
- R8: `out_valid` rises 3 clock edges after the accepting edge in forward mode. In reverse mode it rises 2·16+1+3 = 36 edges after the accepting edge.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. The edge that sees both high clears `out_valid` and raises `in_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands offered |
| in_ready | output | 1 | Unit idle, operands taken on this edge |
| in_mode | input | 1 | 0 = level to duty, 1 = duty to level |
| in_level | input | 8 | Brightness level (forward mode) |
| in_duty | input | 16 | Programmed duty word (reverse mode) |
| in_period | input | 16 | PWM period value |
| in_bitcnt | input | 4 | Counter bit width, 0 means 16 |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 16 | Duty word or 16-bit brightness |
| out_byte | output | 8 | Upper byte of `out_data` |

## Verification
A forward result is due on the third rising edge after the edge that accepted the operands. A reverse result is due 36 edges after that edge, because of the 33-step division plus the multiply and rounding stages. The bench drives inputs and samples outputs on falling edges. It counts the rising edges from acceptance until `out_valid` is first seen, and compares that count with the due cycle before it reads the data. Back-pressure and busy-period checks are made on the falling edges between those points.

// File: rtl/bl_pkg.sv
package bl_pkg;

    // default brightness width; the duty word is twice as wide
    localparam int LVL_W_DEF = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SCALE = 3'd1,
        ST_DIV   = 3'd2,
        ST_MUL   = 3'd3,
        ST_RND   = 3'd4,
        ST_DONE  = 3'd5
    } conv_state_e;

endpackage

// File: rtl/bl_level_scale.sv
// Widens a brightness level to an unsigned 1.(2*LVL_W) fraction by
// replicating its bits three times and rounding on the top dropped bit.
module bl_level_scale #(
    parameter int LVL_W = 8,
    localparam int SCL_W = 2 * LVL_W + 1
) (
    input  logic [LVL_W-1:0] level,
    output logic [SCL_W-1:0] frac
);
    localparam int EXT_W = 3 * LVL_W;

    logic [EXT_W-1:0] ext;

    always_comb begin
        ext  = {3{level}};
        frac = SCL_W'(ext[EXT_W-1:LVL_W]) + SCL_W'(ext[LVL_W-1]);
    end
endmodule

// File: rtl/bl_shift_round.sv
// Shifts a product right by n and adds bit (n-1) as a rounding term.
module bl_shift_round #(
    parameter int PROD_W = 49,
    parameter int OUT_W  = 16,
    parameter int NW     = 5
) (
    input  logic [PROD_W-1:0] prod,
    input  logic [NW-1:0]     n,
    output logic [OUT_W-1:0]  res
);
    localparam int IDX_W = $clog2(PROD_W);

    logic [IDX_W-1:0] rb_idx;
    logic             rb;

    always_comb begin
        rb_idx = IDX_W'(n - 1'b1);
        rb     = prod[rb_idx];
        res    = OUT_W'(prod >> n) + OUT_W'(rb);
    end
endmodule

// File: rtl/bl_restoring_div.sv
// Restoring divider: one quotient bit per cycle, NUM_W cycles per divide.
module bl_restoring_div #(
    parameter int NUM_W = 33,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] dividend,
    input  logic [DEN_W-1:0] divisor,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] acc;
        logic [DEN_W-1:0] dsr;
    } div_regs_t;

    div_regs_t div_d, div_q;
    logic [DEN_W:0] trial;
    logic           qbit;

    always_comb begin
        div_d      = div_q;
        div_d.done = 1'b0;
        trial      = {div_q.rem, div_q.acc[NUM_W-1]};
        qbit       = 1'b0;
        if (start) begin
            div_d.busy = 1'b1;
            div_d.cnt  = CNT_W'(NUM_W);
            div_d.rem  = '0;
            div_d.acc  = dividend;
            div_d.dsr  = divisor;
        end else if (div_q.busy) begin
            if (trial >= {1'b0, div_q.dsr}) begin
                qbit      = 1'b1;
                div_d.rem = DEN_W'(trial - {1'b0, div_q.dsr});
            end else begin
                div_d.rem = DEN_W'(trial);
            end
            div_d.acc = {div_q.acc[NUM_W-2:0], qbit};
            div_d.cnt = div_q.cnt - 1'b1;
            if (div_q.cnt == CNT_W'(1)) begin
                div_d.busy = 1'b0;
                div_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign done = div_q.done;
    assign quot = div_q.acc;
endmodule

// File: rtl/bl_duty_conv.sv
module bl_duty_conv #(
    parameter int LVL_W = bl_pkg::LVL_W_DEF,
    localparam int DUTY_W = 2 * LVL_W,
    localparam int CNT_W  = $clog2(DUTY_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_mode,
    input  logic [LVL_W-1:0]  in_level,
    input  logic [DUTY_W-1:0] in_duty,
    input  logic [DUTY_W-1:0] in_period,
    input  logic [CNT_W-1:0]  in_bitcnt,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DUTY_W-1:0] out_data,
    output logic [LVL_W-1:0]  out_byte
);
    import bl_pkg::*;

    localparam int NW     = CNT_W + 1;
    localparam int SCL_W  = DUTY_W + 1;
    localparam int NUM_W  = 2 * DUTY_W + 1;
    localparam int PROD_W = NUM_W + DUTY_W;

    typedef struct packed {
        conv_state_e       st;
        logic              mode;
        logic [LVL_W-1:0]  lvl;
        logic [NW-1:0]     n;
        logic [DUTY_W-1:0] per;
        logic [NUM_W-1:0]  opa;
        logic [PROD_W-1:0] prod;
        logic [DUTY_W-1:0] res;
    } conv_regs_t;

    conv_regs_t cv_d, cv_q;

    logic [NW-1:0]     n_in;
    logic [SCL_W-1:0]  mask_full;
    logic [DUTY_W-1:0] per_m;
    logic [DUTY_W-1:0] per_div;
    logic [NUM_W-1:0]  num;
    logic              div_start;
    logic              div_done;
    logic [NUM_W-1:0]  div_quot;
    logic [NUM_W:0]    quot_inc;
    logic [SCL_W-1:0]  lvl_frac;
    logic [DUTY_W-1:0] rounded;

    bl_level_scale #(.LVL_W(LVL_W)) u_scale (
        .level (cv_q.lvl),
        .frac  (lvl_frac)
    );

    bl_restoring_div #(.NUM_W(NUM_W), .DEN_W(DUTY_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (num),
        .divisor  (per_div),
        .done     (div_done),
        .quot     (div_quot)
    );

    bl_shift_round #(.PROD_W(PROD_W), .OUT_W(DUTY_W), .NW(NW)) u_round (
        .prod (cv_q.prod),
        .n    (cv_q.n),
        .res  (rounded)
    );

    // operand preparation from the input side
    always_comb begin
        n_in      = (in_bitcnt == '0) ? NW'(DUTY_W) : NW'(in_bitcnt);
        mask_full = (SCL_W'(1) << n_in) - SCL_W'(1);
        per_m     = in_period & mask_full[DUTY_W-1:0];
        per_div   = (per_m == '0) ? '1 : per_m;
        num       = NUM_W'(in_duty) << (n_in + NW'(1));
        quot_inc  = {1'b0, div_quot} + (NUM_W+1)'(1);
    end

    // next-state
    always_comb begin
        cv_d      = cv_q;
        div_start = 1'b0;
        unique case (cv_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    cv_d.mode = in_mode;
                    cv_d.n    = n_in;
                    cv_d.lvl  = in_level;
                    if (in_mode) begin
                        cv_d.per  = per_div;
                        div_start = 1'b1;
                        cv_d.st   = ST_DIV;
                    end else begin
                        cv_d.per = per_m;
                        cv_d.st  = ST_SCALE;
                    end
                end
            end
            ST_SCALE: begin
                cv_d.opa = NUM_W'(lvl_frac);
                cv_d.st  = ST_MUL;
            end
            ST_DIV: begin
                if (div_done) begin
                    cv_d.opa = quot_inc[NUM_W:1];
                    cv_d.st  = ST_MUL;
                end
            end
            ST_MUL: begin
                cv_d.prod = PROD_W'(cv_q.opa) * PROD_W'(cv_q.per);
                cv_d.st   = ST_RND;
            end
            ST_RND: begin
                cv_d.res = rounded;
                cv_d.st  = ST_DONE;
            end
            ST_DONE: begin
                if (out_ready) begin
                    cv_d.st = ST_IDLE;
                end
            end
            default: cv_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cv_q    <= '0;
            cv_q.st <= ST_IDLE;
        end else begin
            cv_q <= cv_d;
        end
    end

    assign in_ready  = (cv_q.st == ST_IDLE);
    assign out_valid = (cv_q.st == ST_DONE);
    assign out_data  = cv_q.res;
    assign out_byte  = cv_q.res[DUTY_W-1 -: LVL_W];
endmodule

// File: rtl/bl_duty_conv_chk.sv
module bl_duty_conv_chk #(
    parameter int LVL_W = 8,
    localparam int DUTY_W  = 2 * LVL_W,
    localparam int LAT_FWD = 3,
    localparam int LAT_REV = 2 * DUTY_W + 1 + 3,
    localparam int LAT_W   = $clog2(LAT_REV + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_mode,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DUTY_W-1:0] out_data
);
    logic [LAT_W-1:0] lat_q;
    logic             mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q  <= '0;
            mode_q <= 1'b0;
        end else if (in_valid && in_ready) begin
            lat_q  <= '0;
            mode_q <= in_mode;
        end else if (lat_q != '1) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (lat_q == (mode_q ? LAT_W'(LAT_REV) : LAT_W'(LAT_FWD))));

    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R7
    result_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9
    result_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (!out_valid && in_ready));
endmodule

bind bl_duty_conv bl_duty_conv_chk #(.LVL_W(LVL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_mode   (in_mode),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/bl_duty_conv_tb.sv
module bl_duty_conv_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_mode = 1'b0;
    logic [7:0]  in_level = '0;
    logic [15:0] in_duty = '0;
    logic [15:0] in_period = '0;
    logic [3:0]  in_bitcnt = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_data;
    logic [7:0]  out_byte;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bl_duty_conv u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_mode   (in_mode),
        .in_level  (in_level),
        .in_duty   (in_duty),
        .in_period (in_period),
        .in_bitcnt (in_bitcnt),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_byte  (out_byte)
    );

    // {mode, level, duty, period, bitcnt, expected}
    localparam int NVEC = 14;
    localparam logic [60:0] VEC [NVEC] = '{
        {1'b0, 8'hEF, 16'h0000, 16'h0024, 4'd6,  16'h86F7},
        {1'b0, 8'hFF, 16'h0000, 16'hFFFF, 4'd0,  16'hFFFF},
        {1'b0, 8'h00, 16'h0000, 16'hFFFF, 4'd0,  16'h0000},
        {1'b0, 8'h80, 16'h0000, 16'h0FA0, 4'd12, 16'h7D7E},
        {1'b0, 8'hFF, 16'h0000, 16'hFFFF, 4'd4,  16'hF000},
        {1'b0, 8'h55, 16'h0000, 16'h0000, 4'd8,  16'h0000},
        {1'b0, 8'h55, 16'h0000, 16'h0100, 4'd8,  16'h0000},
        {1'b0, 8'h01, 16'h0000, 16'hFFFF, 4'd0,  16'h0101},
        {1'b1, 8'h00, 16'h86F7, 16'h0024, 4'd6,  16'h86F7},
        {1'b1, 8'h00, 16'h8000, 16'h0000, 4'd0,  16'h8000},
        {1'b1, 8'h00, 16'hFFFF, 16'hFFFF, 4'd0,  16'hFFFF},
        {1'b1, 8'h00, 16'h0010, 16'h0FA0, 4'd12, 16'h0010},
        {1'b1, 8'h00, 16'h0000, 16'h0FA0, 4'd12, 16'h0000},
        {1'b1, 8'h00, 16'h0003, 16'h0007, 4'd3,  16'h0003}
    };

    task automatic check(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
        end
    endtask

    // offers one operation, returns when out_valid is seen (edges since accept)
    task automatic run_op(input logic m, input logic [7:0] l, input logic [15:0] d,
                          input logic [15:0] p, input logic [3:0] c, output int lat);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid  = 1'b1;
        in_mode   = m;
        in_level  = l;
        in_duty   = d;
        in_period = p;
        in_bitcnt = c;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        lat = 0;
        while (!out_valid && lat < 200) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lat;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        check(out_data == 16'h0, "R1 out_data after reset", int'(out_data), 0);

        // table: R2 R3 R4 forward, R3 R5 reverse, R6 byte, R8 latency
        for (int i = 0; i < NVEC; i++) begin
            logic [60:0] v;
            int exp_lat;
            v = VEC[i];
            exp_lat = v[60] ? 36 : 3;
            run_op(v[60], v[59:52], v[51:36], v[35:20], v[19:16], lat);
            if (v[60])
                check(out_data == v[15:0], $sformatf("R5 R3 reverse vec %0d", i),
                      int'(out_data), int'(v[15:0]));
            else
                check(out_data == v[15:0], $sformatf("R2 R3 R4 forward vec %0d", i),
                      int'(out_data), int'(v[15:0]));
            check(out_byte == v[15:8], $sformatf("R6 byte vec %0d", i),
                  int'(out_byte), int'(v[15:8]));
            check(lat == exp_lat, $sformatf("R8 latency vec %0d", i), lat, exp_lat);
        end

        // R7: busy unit ignores new offers
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_mode = 1'b1; in_duty = 16'h86F7;
        in_period = 16'h0024; in_bitcnt = 4'd6;
        @(posedge clk);
        @(negedge clk);
        in_mode = 1'b0; in_level = 8'hFF; in_duty = 16'h1234;
        in_period = 16'hFFFF; in_bitcnt = 4'd0;
        check(in_ready == 1'b0, "R7 in_ready low while busy", int'(in_ready), 0);
        repeat (10) @(negedge clk);
        check(in_ready == 1'b0, "R7 in_ready low mid-divide", int'(in_ready), 0);
        in_valid = 1'b0;
        lat = 0;
        while (!out_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        check(out_data == 16'h86F7, "R7 result unaffected by ignored offer",
              int'(out_data), 16'h86F7);

        // R9: back-pressure holds the result
        @(negedge clk);
        out_ready = 1'b0;
        run_op(1'b0, 8'hEF, 16'h0, 16'h0024, 4'd6, lat);
        repeat (5) @(negedge clk);
        check(out_valid == 1'b1, "R9 out_valid held", int'(out_valid), 1);
        check(out_data == 16'h86F7, "R9 out_data held", int'(out_data), 16'h86F7);
        check(in_ready == 1'b0, "R9 in_ready low while held", int'(in_ready), 0);
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R9 out_valid cleared after handshake", int'(out_valid), 0);
        check(in_ready == 1'b1, "R9 in_ready back after handshake", int'(in_ready), 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule